// File: doc/BRIEF.md
# Mean-magnitude ternary weight quantizer

This block turns a matrix of signed fixed-point weights into ternary codes. The weights arrive one per beat on a valid/ready input stream, in row-major order. Each weight is written into an internal buffer, and its magnitude is added to a running total. When the last weight of the matrix has been taken, a sequential divider runs once. It turns the total into the mean magnitude, with `FRAC` fraction bits. This mean is the scale of the matrix.

The buffer is then replayed. Rounding a weight divided by (scale + epsilon) and clipping it to ±1 is the same as one comparison: the weight maps to its sign when twice its magnitude reaches (scale + epsilon), and to zero otherwise. The codes leave on a valid/ready output stream, packed `PACK` to a word. One scale covers the whole matrix. It is presented on `scale_o` next to the codes, for rescaling further down the path.

Back-pressure works as follows. While a matrix is being loaded, `w_ready` is high and a beat is taken on any edge where `w_valid` is high. From the last weight until the final code word is accepted, `w_ready` is low. While `q_valid` is high and `q_ready` is low, the output word is held unchanged. The producer may drop `w_valid` between beats, and the consumer may stall for any number of cycles.

Top module: `tern_quant`

## Requirements
- R1: `scale_o` equals floor(sum of |w| × 2^FRAC / (ROWS×COLS)). It is an unsigned value with FRAC fraction bits. It holds its value for as long as `q_valid` is high.
- R2: A weight's code is its sign when 2×|w|×2^FRAC ≥ scale_o + EPS, and zero otherwise. EPS is counted in scale LSBs and is at least 1, so a weight that sits exactly on half the scale maps to zero.
- R3: The code for zero is 2'b00, for +1 it is 2'b01, and for −1 it is 2'b11. The value 2'b10 never appears on `q_data`.
- R4: Element k of a word sits in bits [2k+1:2k], so the packing is LSB-first. Word j holds weights j×PACK to j×PACK+PACK−1, in arrival order. `q_last` is high only on the final word of a matrix.
- R5: An all-zero matrix gives a scale of 0 and all-zero codes.
- R6: While `q_valid` is high and `q_ready` is low, `q_data`, `q_last` and `q_valid` do not change.
- R7: `w_ready` and `q_valid` are never high together. After the final word is accepted, `w_ready` returns high.
- R8: The first code word is valid NUMW+2 clock edges after the edge that takes the last weight, where NUMW = WBITS + clog2(ROWS×COLS) + FRAC.
- R9: After reset, `q_valid` is 0, `w_ready` is 1 and `scale_o` is 0.
- R10: Weights in rows of very different magnitude are all compared against the same matrix-wide scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| w_valid | input | 1 | Weight beat valid |
| w_ready | output | 1 | Block can take a weight |
| w_data | input | WBITS | Signed weight, row-major order |
| q_valid | output | 1 | Code word valid |
| q_ready | input | 1 | Consumer takes the code word |
| q_data | output | 2×PACK | Packed ternary codes |
| q_last | output | 1 | Final word of the matrix |
| scale_o | output | WBITS+clog2(ROWS×COLS)+FRAC | Mean magnitude, FRAC fraction bits |

## Verification
The only result with a fixed due time is the first code word. The bench counts falling edges from the edge that takes the last weight, and expects `q_valid` on the NUMW+3rd of them, which is NUMW+2 rising edges. Later words depend only on the handshake. The bench compares each word, `q_last` and the scale at the falling edge before it raises `q_ready`. During an injected stall it compares the same word again one cycle later. After the final handshake it checks at the next falling edge that the input side has reopened.

// File: rtl/tq_pkg.sv
package tq_pkg;
  typedef enum logic [1:0] {
    TQ_ZERO = 2'b00,
    TQ_POS  = 2'b01,
    TQ_NEG  = 2'b11
  } tcode_e;
endpackage

// File: rtl/tq_seqdiv.sv
// Restoring divider: one quotient bit per clock, NUMW steps per division.
module tq_seqdiv #(
  parameter int NUMW = 17,
  parameter int DENW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NUMW-1:0] num,
  input  logic [DENW-1:0] den,
  output logic            done,
  output logic [NUMW-1:0] quot
);
  localparam int CW = $clog2(NUMW + 1);

  logic [DENW-1:0] rem;
  logic [NUMW-1:0] q;
  logic [CW-1:0]   cnt;
  logic            busy;
  logic [DENW:0]   trial;
  logic [DENW:0]   diff;
  logic            ge;

  always_comb begin
    trial = {rem, q[NUMW-1]};
    ge    = trial >= {1'b0, den};
    diff  = trial - {1'b0, den};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem  <= '0;
      q    <= '0;
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start) begin
      rem  <= '0;
      q    <= num;
      cnt  <= CW'(NUMW);
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt != '0) begin
        rem <= ge ? diff[DENW-1:0] : trial[DENW-1:0];
        q   <= {q[NUMW-2:0], ge};
        cnt <= cnt - CW'(1);
      end else begin
        busy <= 1'b0;
      end
    end
  end

  assign done = busy && (cnt == '0);
  assign quot = q;
endmodule

// File: rtl/tq_wbuf.sv
// Matrix store: written one weight per beat, read one packed word of weights at a time.
module tq_wbuf #(
  parameter int N     = 32,
  parameter int WBITS = 8,
  parameter int PACK  = 8,
  parameter int IW    = 5,
  parameter int WW    = 2
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic [IW-1:0]         wr_idx,
  input  logic [WBITS-1:0]      wr_data,
  input  logic [WW-1:0]         rd_word,
  output logic [PACK*WBITS-1:0] rd_data
);
  logic [WBITS-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_comb begin
    for (int k = 0; k < PACK; k++)
      rd_data[k*WBITS +: WBITS] = mem[IW'(int'(rd_word) * PACK + k)];
  end
endmodule

// File: rtl/tq_pack.sv
// Threshold compare per lane: the round-and-clip step reduces to one magnitude test.
module tq_pack #(
  parameter int WBITS = 8,
  parameter int FRAC  = 4,
  parameter int EPS   = 1,
  parameter int PACK  = 8,
  parameter int SCW   = 17
) (
  input  logic [PACK*WBITS-1:0] weights,
  input  logic [SCW-1:0]        scale,
  output logic [2*PACK-1:0]     codes
);
  import tq_pkg::*;
  localparam int CMPW = WBITS + FRAC + SCW + 1;

  logic [CMPW-1:0] thresh;
  assign thresh = CMPW'(scale) + CMPW'(EPS);

  for (genvar k = 0; k < PACK; k++) begin : g_lane
    logic [WBITS-1:0] wv;
    logic [WBITS-1:0] mag;
    logic [CMPW-1:0]  lhs;
    tcode_e           code;
    always_comb begin
      wv   = weights[k*WBITS +: WBITS];
      mag  = wv[WBITS-1] ? (~wv + WBITS'(1)) : wv;
      lhs  = CMPW'(mag) << (FRAC + 1);
      if (lhs >= thresh) code = wv[WBITS-1] ? TQ_NEG : TQ_POS;
      else               code = TQ_ZERO;
    end
    assign codes[2*k +: 2] = code;
  end
endmodule

// File: rtl/tern_quant.sv
module tern_quant #(
  parameter int ROWS  = 4,
  parameter int COLS  = 8,
  parameter int WBITS = 8,
  parameter int FRAC  = 4,
  parameter int EPS   = 1,
  parameter int PACK  = 8,
  localparam int N    = ROWS * COLS,
  localparam int SCW  = WBITS + $clog2(N) + FRAC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              w_valid,
  output logic              w_ready,
  input  logic [WBITS-1:0]  w_data,
  output logic              q_valid,
  input  logic              q_ready,
  output logic [2*PACK-1:0] q_data,
  output logic              q_last,
  output logic [SCW-1:0]    scale_o
);
  localparam int WORDS = N / PACK;
  localparam int SUMW  = WBITS + $clog2(N);
  localparam int DENW  = $clog2(N + 1);
  localparam int IW    = $clog2(N);
  localparam int WW    = (WORDS > 1) ? $clog2(WORDS) : 1;

  typedef enum logic [1:0] {ST_LOAD, ST_KICK, ST_DIV, ST_EMIT} state_e;

  state_e              state;
  logic [SUMW-1:0]     sum;
  logic [IW-1:0]       wr_idx;
  logic [WW-1:0]       rd_word;
  logic [SCW-1:0]      scale_q;
  logic [WBITS-1:0]    mag;
  logic                take;
  logic                div_done;
  logic [SCW-1:0]      quot;
  logic [PACK*WBITS-1:0] rd_data;

  assign w_ready = (state == ST_LOAD);
  assign take    = w_ready && w_valid;
  assign mag     = w_data[WBITS-1] ? (~w_data + WBITS'(1)) : w_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_LOAD;
      sum     <= '0;
      wr_idx  <= '0;
      rd_word <= '0;
      scale_q <= '0;
    end else begin
      case (state)
        ST_LOAD: if (take) begin
          sum <= sum + SUMW'(mag);
          if (wr_idx == IW'(N - 1)) begin
            wr_idx <= '0;
            state  <= ST_KICK;
          end else begin
            wr_idx <= wr_idx + IW'(1);
          end
        end
        ST_KICK: begin
          sum   <= '0;
          state <= ST_DIV;
        end
        ST_DIV: if (div_done) begin
          scale_q <= quot;
          rd_word <= '0;
          state   <= ST_EMIT;
        end
        ST_EMIT: if (q_ready) begin
          if (rd_word == WW'(WORDS - 1)) begin
            rd_word <= '0;
            state   <= ST_LOAD;
          end else begin
            rd_word <= rd_word + WW'(1);
          end
        end
        default: state <= ST_LOAD;
      endcase
    end
  end

  tq_seqdiv #(.NUMW(SCW), .DENW(DENW)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (state == ST_KICK),
    .num   ({sum, {FRAC{1'b0}}}),
    .den   (DENW'(N)),
    .done  (div_done),
    .quot  (quot)
  );

  tq_wbuf #(.N(N), .WBITS(WBITS), .PACK(PACK), .IW(IW), .WW(WW)) u_buf (
    .clk     (clk),
    .wr_en   (take),
    .wr_idx  (wr_idx),
    .wr_data (w_data),
    .rd_word (rd_word),
    .rd_data (rd_data)
  );

  tq_pack #(.WBITS(WBITS), .FRAC(FRAC), .EPS(EPS), .PACK(PACK), .SCW(SCW)) u_pack (
    .weights (rd_data),
    .scale   (scale_q),
    .codes   (q_data)
  );

  assign q_valid = (state == ST_EMIT);
  assign q_last  = q_valid && (rd_word == WW'(WORDS - 1));
  assign scale_o = scale_q;
endmodule

// File: rtl/tern_quant_chk.sv
module tern_quant_chk #(
  parameter int PACK = 8,
  parameter int SCW  = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              w_ready,
  input logic              q_valid,
  input logic              q_ready,
  input logic [2*PACK-1:0] q_data,
  input logic              q_last,
  input logic [SCW-1:0]    scale_o
);
  logic bad_code;
  always_comb begin
    bad_code = 1'b0;
    for (int k = 0; k < PACK; k++)
      if (q_data[2*k +: 2] == 2'b10) bad_code = 1'b1;
  end

  // R3
  codes_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |-> !bad_code);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !q_ready) |=> (q_valid && $stable(q_data) && $stable(q_last)));

  // R1
  scale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && $past(q_valid)) |-> $stable(scale_o));

  // R7
  side_mutex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_ready && q_valid));

  // R4
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_last |-> q_valid);
endmodule

bind tern_quant tern_quant_chk #(.PACK(PACK), .SCW(SCW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .w_ready (w_ready),
  .q_valid (q_valid),
  .q_ready (q_ready),
  .q_data  (q_data),
  .q_last  (q_last),
  .scale_o (scale_o)
);

// File: tb/tern_quant_tb_top.sv
module tern_quant_tb_top;
  localparam int ROWS = 4, COLS = 8, WBITS = 8, FRAC = 4, EPS = 1, PACK = 8;
  localparam int N = ROWS * COLS;
  localparam int WORDS = N / PACK;
  localparam int SCW = WBITS + $clog2(N) + FRAC;
  localparam int LAT = SCW + 3; // falling edges counted from the accepting edge

  // {stall, kind, seed}: kind 0 full range, 1 small, 2 row-scaled, 3 sparse
  localparam logic [34:0] VEC [5] = '{
    {1'b0, 2'd0, 32'h1234_5678},
    {1'b1, 2'd0, 32'hDEAD_BEEF},
    {1'b0, 2'd1, 32'h0BAD_F00D},
    {1'b1, 2'd2, 32'hCAFE_0001},
    {1'b0, 2'd3, 32'h7777_1111}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic w_valid = 1'b0, q_ready = 1'b0;
  logic [WBITS-1:0] w_data = '0;
  logic w_ready, q_valid, q_last;
  logic [2*PACK-1:0] q_data;
  logic [SCW-1:0] scale_o;

  int n_chk = 0, n_bad = 0;
  bit fin = 1'b0;
  logic signed [WBITS-1:0] wm [N];

  always #5 clk = ~clk;

  tern_quant #(.ROWS(ROWS), .COLS(COLS), .WBITS(WBITS), .FRAC(FRAC),
               .EPS(EPS), .PACK(PACK)) dut_i (
    .clk(clk), .rst_n(rst_n), .w_valid(w_valid), .w_ready(w_ready),
    .w_data(w_data), .q_valid(q_valid), .q_ready(q_ready),
    .q_data(q_data), .q_last(q_last), .scale_o(scale_o));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint mag_of(input logic signed [WBITS-1:0] v);
    return (v < 0) ? -longint'(v) : longint'(v);
  endfunction

  function automatic longint exp_scale();
    longint s = 0;
    for (int i = 0; i < N; i++) s += mag_of(wm[i]);
    return (s * (1 << FRAC)) / N;
  endfunction

  function automatic logic [2*PACK-1:0] exp_word(input int j, input longint sc);
    logic [2*PACK-1:0] w = '0;
    for (int k = 0; k < PACK; k++) begin
      longint m = mag_of(wm[j*PACK + k]);
      if (2 * m * (1 << FRAC) >= sc + EPS)
        w[2*k +: 2] = (wm[j*PACK + k] < 0) ? 2'b11 : 2'b01;
    end
    return w;
  endfunction

  task automatic fill(input logic [1:0] kind, input logic [31:0] seed);
    logic [31:0] s = seed;
    for (int i = 0; i < N; i++) begin
      logic signed [WBITS-1:0] t;
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      t = s[WBITS-1:0];
      case (kind)
        2'd0: wm[i] = t;
        2'd1: begin
          wm[i] = WBITS'(s[1:0]);
          if (s[2]) wm[i] = -wm[i];
        end
        2'd2: wm[i] = t >>> (3 - (i / COLS));
        default: wm[i] = (s[3:0] == 4'd0) ? (t | 8'sh40) : '0;
      endcase
    end
  endtask

  task automatic run_matrix(input bit stall, input string tag);
    longint sc;
    int cyc;
    sc = exp_scale();
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      if (stall && (i % 5 == 2)) begin
        w_valid = 1'b0;
        @(negedge clk);
      end
      w_valid = 1'b1;
      w_data  = wm[i];
      @(posedge clk);
    end
    @(negedge clk);
    w_valid = 1'b0;
    cyc = 1;
    // R7: input side closed right after the last weight
    chk(w_ready == 1'b0, {"R7 ", tag}, w_ready, 0);
    while (!q_valid && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    // R8: first word latency
    chk(cyc == LAT, {"R8 ", tag}, cyc, LAT);
    // R1: matrix-wide mean magnitude
    chk(scale_o == SCW'(sc), {"R1 ", tag}, scale_o, sc);
    for (int j = 0; j < WORDS; j++) begin
      logic [2*PACK-1:0] ew = exp_word(j, sc);
      // R2 R4 R10: codes and packing
      chk(q_valid && q_data == ew, {"R2 ", tag}, q_data, ew);
      chk(q_last == (j == WORDS - 1), {"R4 ", tag}, q_last, (j == WORDS - 1));
      if (stall) begin
        @(negedge clk);
        // R6: word held under back-pressure
        chk(q_valid && q_data == ew && scale_o == SCW'(sc), {"R6 ", tag}, q_data, ew);
      end
      q_ready = 1'b1;
      @(negedge clk);
      q_ready = 1'b0;
    end
    // R7: input side reopens after the final word
    chk(w_ready && !q_valid, {"R7 reopen ", tag}, {w_ready, q_valid}, 2'b10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(q_valid == 1'b0 && w_ready == 1'b1 && scale_o == '0, "R9 reset",
        {q_valid, w_ready, scale_o}, {2'b01, {SCW{1'b0}}});
    rst_n = 1'b1;

    foreach (VEC[v]) begin
      fill(VEC[v][33:32], VEC[v][31:0]);
      run_matrix(VEC[v][34], $sformatf("vec%0d", v));
    end

    // R5: all-zero matrix
    for (int i = 0; i < N; i++) wm[i] = '0;
    run_matrix(1'b0, "r5_zero");
    chk(scale_o == '0, "R5 zero scale", scale_o, 0);

    // R2: weight exactly at half the scale falls to zero because of EPS
    for (int i = 0; i < N; i++) begin
      if (i < 14)      wm[i] = (i % 2) ? -8'sd4 : 8'sd4;
      else if (i < 22) wm[i] = (i % 2) ? -8'sd1 : 8'sd1;
      else             wm[i] = '0;
    end
    run_matrix(1'b1, "r2_tie");
    chk(scale_o == SCW'(32), "R2 tie scale", scale_o, 32);

    // R3: most negative weight everywhere gives all -1 codes (2'b11)
    for (int i = 0; i < N; i++) wm[i] = -8'sd128;
    run_matrix(1'b0, "r3_neg");

    // R10: one large row and three tiny rows share the scale
    for (int i = 0; i < N; i++) wm[i] = (i < COLS) ? 8'sd100 : ((i % 2) ? 8'sd3 : -8'sd3);
    run_matrix(1'b0, "r10_rows");

    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule